// File: doc/BRIEF.md
# Redundant Reference Clock Selector

This block picks one of two reference clocks, input A and input B, and passes it to a single output clock through a glitch-free multiplexer. A configuration bit says which physical input is the primary; the other input is the secondary. A two-bit mode field chooses how the source is picked. In manual operation an external select pin chooses primary or secondary. In automatic revertive operation the block falls back to the secondary when the primary stops and returns to the primary once it has been running again for a full qualification window.

Each input is watched by an activity monitor clocked from a free-running internal oscillator. The oscillator must run at more than twice the faster reference. From this activity a loss flag is raised whenever the currently chosen input is not running. The flag is also high when neither input is running. Automatic switching is honoured only when input A is the primary. With input B as primary, automatic mode stays on the primary.

Top module: `ref_switch_top`

## Requirements
- R1: With mode 2'b00 or 2'b01 (manual), `sel_b` equals `prim_b` XOR `sel_pin`: pin low picks the primary and pin high picks the secondary. `sel_b` = 1 means input B is routed to `clk_out`.
- R2: Mode 2'b10 is reserved and behaves exactly like manual mode.
- R3: `prim_b` = 0 makes input A the primary and input B the secondary. `prim_b` = 1 swaps the two roles.
- R4: In mode 2'b11 with `prim_b` = 0, `sel_b` goes to 1 when input A is lost while input B is present, and `loss_clk` stays low.
- R5: In that revertive mode, `sel_b` returns to 0 only after input A has been present for QUAL_CYC (16) consecutive oscillator cycles. It is still 1 eight cycles after A restarts.
- R6: In mode 2'b11 with `prim_b` = 1, the block never switches: `sel_b` stays 1 even when input B is lost.
- R7: `loss_clk` is high whenever the selected input is lost, and it is always high when both inputs are lost.
- R8: An input is declared lost only after LOSS_CYC (16) oscillator cycles without an edge. It is not lost 10 cycles after it stops, and it is lost 40 cycles after it stops.
- R9: Once settled, `clk_out` equals the selected input. During any switchover, no high or low pulse on `clk_out` is shorter than the shortest input half-period.
- R10: During reset `loss_clk` = 1, `sel_b` = 0 and `clk_out` = 0. An input is qualified again before `loss_clk` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Free-running internal oscillator for monitoring and control |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_a | input | 1 | Reference input A (crystal/reference) |
| clk_b | input | 1 | Reference input B |
| mode | input | 2 | Switchover mode: 0x manual, 10 reserved (manual), 11 automatic revertive |
| prim_b | input | 1 | Primary is input B when 1, input A when 0 |
| sel_pin | input | 1 | Manual select: 0 primary, 1 secondary |
| clk_out | output | 1 | Glitch-free selected clock |
| sel_b | output | 1 | Current selection, 1 = input B |
| loss_clk | output | 1 | Selected input lost |

## Verification
The bench sweeps all twelve combinations of the three manual-type mode codes, the primary bit and the select pin. Because the two inputs run at different periods, comparing `clk_out` against each input shows which one is routed, and this is also how the reserved code is separated from manual operation. Stopping each clock in turn, low, tells the manual hold apart from the automatic fallback. A probe eight cycles after restart separates immediate reversion from qualified reversion, and stopping input B while it is primary confirms the no-switch rule. A continuous pulse-width monitor on `clk_out` across every switchover catches glitches.

// File: rtl/ref_switch_pkg.sv
package ref_switch_pkg;

    typedef enum logic [1:0] {
        SW_MANUAL0  = 2'b00,
        SW_MANUAL1  = 2'b01,
        SW_RESERVED = 2'b10,
        SW_AUTO     = 2'b11
    } sw_mode_e;

endpackage

// File: rtl/ref_activity_mon.sv
module ref_activity_mon #(
    parameter int LOSS_CYC = 16,
    parameter int QUAL_CYC = 16
) (
    input  logic osc_clk,
    input  logic rst_n,
    input  logic ref_clk,
    output logic alive
);
    localparam int GW = $clog2(LOSS_CYC + 1);
    localparam int QW = (QUAL_CYC > 1) ? $clog2(QUAL_CYC) : 1;
    localparam logic [GW-1:0] GAP_MAX  = GW'(LOSS_CYC);
    localparam logic [GW-1:0] GAP_LIM  = GW'(LOSS_CYC - 1);
    localparam logic [QW-1:0] QUAL_LIM = QW'(QUAL_CYC - 1);

    typedef struct packed {
        logic [1:0]    sync;
        logic          prev;
        logic [GW-1:0] gap;
        logic [QW-1:0] qual;
        logic          alive;
    } mon_t;

    mon_t st_q, st_d;
    logic edge_seen;
    logic lapse;

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[0], ref_clk};
        st_d.prev = st_q.sync[1];
        edge_seen = st_q.sync[1] ^ st_q.prev;
        lapse     = !edge_seen && (st_q.gap >= GAP_LIM);
        if (edge_seen)
            st_d.gap = '0;
        else if (st_q.gap != GAP_MAX)
            st_d.gap = st_q.gap + 1'b1;
        if (lapse) begin
            st_d.alive = 1'b0;
            st_d.qual  = '0;
        end else if (!st_q.alive) begin
            if (st_q.qual == QUAL_LIM) begin
                st_d.alive = 1'b1;
                st_d.qual  = '0;
            end else begin
                st_d.qual = st_q.qual + 1'b1;
            end
        end
    end

    always_ff @(posedge osc_clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '{sync: 2'b00, prev: 1'b0, gap: GAP_MAX, qual: '0, alive: 1'b0};
        else
            st_q <= st_d;
    end

    assign alive = st_q.alive;

    // R8
    gap_bound_chk: assert property (@(posedge osc_clk) disable iff (!rst_n)
        st_q.gap <= GAP_MAX);

    // R8
    edge_keeps_alive_chk: assert property (@(posedge osc_clk) disable iff (!rst_n)
        (st_q.alive && edge_seen) |=> st_q.alive);

endmodule

// File: rtl/ref_switch_ctrl.sv
module ref_switch_ctrl
    import ref_switch_pkg::*;
(
    input  logic       osc_clk,
    input  logic       rst_n,
    input  logic [1:0] mode,
    input  logic       prim_b,
    input  logic       sel_pin,
    input  logic       alive_a,
    input  logic       alive_b,
    output logic       sel_b,
    output logic       loss
);
    typedef struct packed {
        logic [1:0] pin_s;
        logic       use_sec;
        logic       sel_b;
        logic       loss;
    } ctl_t;

    ctl_t st_q, st_d;
    sw_mode_e mode_e;
    logic prim_alive, sec_alive;

    always_comb begin
        mode_e     = sw_mode_e'(mode);
        prim_alive = prim_b ? alive_b : alive_a;
        sec_alive  = prim_b ? alive_a : alive_b;
        st_d       = st_q;
        st_d.pin_s = {st_q.pin_s[0], sel_pin};
        if (mode_e != SW_AUTO)
            st_d.use_sec = st_q.pin_s[1];
        else if (prim_b)
            st_d.use_sec = 1'b0;
        else if (st_q.use_sec)
            st_d.use_sec = !prim_alive;
        else
            st_d.use_sec = !prim_alive && sec_alive;
        st_d.sel_b = prim_b ^ st_d.use_sec;
        st_d.loss  = !(st_d.sel_b ? alive_b : alive_a);
    end

    always_ff @(posedge osc_clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '{pin_s: 2'b00, use_sec: 1'b0, sel_b: 1'b0, loss: 1'b1};
        else
            st_q <= st_d;
    end

    assign sel_b = st_q.sel_b;
    assign loss  = st_q.loss;

    // R6
    auto_prim_b_hold_chk: assert property (@(posedge osc_clk) disable iff (!rst_n)
        (mode == 2'b11 && prim_b) ##1 (mode == 2'b11 && prim_b) |-> sel_b);

    // R7
    both_lost_flag_chk: assert property (@(posedge osc_clk) disable iff (!rst_n)
        (!alive_a && !alive_b) |=> loss);

    // R4
    no_fallback_to_dead_chk: assert property (@(posedge osc_clk) disable iff (!rst_n)
        (mode == 2'b11 && !prim_b && !alive_b && !st_q.use_sec) |=> !st_q.use_sec);

endmodule

// File: rtl/glitchfree_leg.sv
module glitchfree_leg (
    input  logic clk,
    input  logic clr,
    input  logic want,
    input  logic other_en,
    output logic en
);
    logic [1:0] sync_q, sync_d;
    logic       en_q;

    always_comb begin
        sync_d = {sync_q[0], want & ~other_en};
    end

    always_ff @(posedge clk or posedge clr) begin
        if (clr)
            sync_q <= 2'b00;
        else
            sync_q <= sync_d;
    end

    always_ff @(negedge clk or posedge clr) begin
        if (clr)
            en_q <= 1'b0;
        else
            en_q <= sync_q[1];
    end

    assign en = en_q;

endmodule

// File: rtl/ref_switch_top.sv
module ref_switch_top #(
    parameter int LOSS_CYC = 16,
    parameter int QUAL_CYC = 16
) (
    input  logic       osc_clk,
    input  logic       rst_n,
    input  logic       clk_a,
    input  logic       clk_b,
    input  logic [1:0] mode,
    input  logic       prim_b,
    input  logic       sel_pin,
    output logic       clk_out,
    output logic       sel_b,
    output logic       loss_clk
);
    logic [1:0] ref_in;
    logic [1:0] alive;
    logic [1:0] en;
    logic [1:0] want;
    logic [1:0] clr;

    assign ref_in = {clk_b, clk_a};

    generate
        for (genvar i = 0; i < 2; i++) begin : g_in
            ref_activity_mon #(.LOSS_CYC(LOSS_CYC), .QUAL_CYC(QUAL_CYC)) u_mon (
                .osc_clk (osc_clk),
                .rst_n   (rst_n),
                .ref_clk (ref_in[i]),
                .alive   (alive[i])
            );
            assign clr[i] = !rst_n || !alive[i];
            glitchfree_leg u_leg (
                .clk      (ref_in[i]),
                .clr      (clr[i]),
                .want     (want[i]),
                .other_en (en[1-i]),
                .en       (en[i])
            );
        end
    endgenerate

    ref_switch_ctrl u_ctrl (
        .osc_clk (osc_clk),
        .rst_n   (rst_n),
        .mode    (mode),
        .prim_b  (prim_b),
        .sel_pin (sel_pin),
        .alive_a (alive[0]),
        .alive_b (alive[1]),
        .sel_b   (sel_b),
        .loss    (loss_clk)
    );

    assign want    = {sel_b, ~sel_b};
    assign clk_out = (clk_a & en[0]) | (clk_b & en[1]);

    // R9
    single_enable_chk: assert property (@(posedge osc_clk) disable iff (!rst_n)
        $onehot0(en));

endmodule

// File: tb/ref_switch_top_test.sv
module ref_switch_top_test;
    localparam int OSC_PERIOD = 10;
    localparam int A_HALF = 25;
    localparam int B_HALF = 35;

    logic osc_clk = 0, rst_n = 0, clk_a = 0, clk_b = 0;
    logic [1:0] mode = 2'b00;
    logic prim_b = 0, sel_pin = 0;
    logic run_a = 1, run_b = 1;
    logic clk_out, sel_b, loss_clk;
    int checks = 0, errors = 0, glitches = 0;
    realtime last_edge = 0;

    ref_switch_top uut (.osc_clk(osc_clk), .rst_n(rst_n), .clk_a(clk_a), .clk_b(clk_b),
        .mode(mode), .prim_b(prim_b), .sel_pin(sel_pin),
        .clk_out(clk_out), .sel_b(sel_b), .loss_clk(loss_clk));

    always #(OSC_PERIOD/2) osc_clk = ~osc_clk;
    initial forever begin #(A_HALF); if (run_a || clk_a) clk_a = ~clk_a; end
    initial forever begin #(B_HALF); if (run_b || clk_b) clk_b = ~clk_b; end

    // R9: pulse width monitor on clk_out
    always @(clk_out) begin
        if (last_edge > 0 && ($realtime - last_edge) < A_HALF - 1) glitches++;
        last_edge = $realtime;
    end

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(posedge osc_clk);
        #2;
    endtask

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic chk_route(input string tag, input bit exp_b);
        int bad = 0;
        for (int i = 0; i < 60; i++) begin
            wait_cyc(1);
            if (clk_out !== (exp_b ? clk_b : clk_a)) bad++;
        end
        chk(bad == 0, tag, bad, 0);
    endtask

    initial begin
        #(OSC_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        wait_cyc(5);
        chk(loss_clk == 1, "R10 reset loss", loss_clk, 1);
        chk(sel_b == 0, "R10 reset sel", sel_b, 0);
        chk(clk_out == 0, "R10 reset clk_out", clk_out, 0);
        rst_n = 1;
        wait_cyc(100);
        chk(loss_clk == 0, "R10 qualified", loss_clk, 0);

        // R1 R2 R3 sweep
        for (int m = 0; m < 3; m++)
            for (int p = 0; p < 2; p++)
                for (int s = 0; s < 2; s++) begin
                    mode = 2'(m); prim_b = 1'(p); sel_pin = 1'(s);
                    wait_cyc(300);
                    chk(sel_b == (p ^ s), m == 2 ? "R2 reserved sel" : "R1 R3 manual sel",
                        sel_b, p ^ s);
                    chk_route("R9 route", 1'(p ^ s));
                end

        mode = 2'b00; prim_b = 0; sel_pin = 0;
        wait_cyc(200);
        run_a = 0;
        wait_cyc(10);
        chk(loss_clk == 0, "R8 not early", loss_clk, 0);
        wait_cyc(30);
        chk(loss_clk == 1, "R7 R8 selected lost", loss_clk, 1);
        chk(sel_b == 0, "R1 manual holds", sel_b, 0);
        mode = 2'b11;
        wait_cyc(10);
        chk(sel_b == 1, "R4 fallback", sel_b, 1);
        chk(loss_clk == 0, "R4 loss clear", loss_clk, 0);
        wait_cyc(100);
        chk_route("R4 route b", 1'b1);
        run_a = 1;
        wait_cyc(8);
        chk(sel_b == 1, "R5 not yet reverted", sel_b, 1);
        wait_cyc(100);
        chk(sel_b == 0, "R5 reverted", sel_b, 0);
        chk_route("R5 route a", 1'b0);

        run_a = 0; run_b = 0;
        wait_cyc(60);
        chk(loss_clk == 1, "R7 both lost", loss_clk, 1);
        run_a = 1; run_b = 1;
        wait_cyc(200);

        prim_b = 1;
        wait_cyc(100);
        chk(sel_b == 1, "R6 on primary b", sel_b, 1);
        run_b = 0;
        wait_cyc(60);
        chk(sel_b == 1, "R6 no switch", sel_b, 1);
        chk(loss_clk == 1, "R6 R7 loss", loss_clk, 1);
        run_b = 1;
        wait_cyc(100);
        chk(loss_clk == 0, "R8 requalified", loss_clk, 0);

        chk(glitches == 0, "R9 glitch-free", glitches, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule